// File: doc/BRIEF.md
# Elastic Buffer Self-Check Monitor

This block sits beside the write/read elastic data buffer of a multiplexer card and checks that buffer while it is in live use. It does not inject test patterns. Whenever the write address held by the buffer equals the read counter address and the gated clock qualifier is high, it samples one bit that enters the buffer and the matching bit that leaves it, and flags a fault when the two differ. In encode mode the incoming bit comes from a duplicated 3-bit transition code, and successive compares step through its bit positions. In recovery mode the incoming bit is the conditioned data of the second receiver.

Two activity watchdogs confirm that compare enables keep arriving and that the selected timing strobe keeps toggling. A fourth check compares the two redundant receiver paths against each other. Any of the four faults sets a sticky card error. The error stays set until a synchronous clear is applied.

The block drives a shared active-low stuff request line. In the diagnostic word of each frame, the line carries the card error status. In every other word, it carries the positive stuff request from the external decoder. The buffer, the receivers, the transition encoder and the stuff decision logic are all outside the block.

Top module: `buf_selfcheck_mon`

## Requirements
- R1: A bit compare takes place only for an edge where `wr_addr_i == rd_addr_i` and `gate_i` is 1. Differing bits sampled with unequal addresses never set the card error.
- R2: When `gate_i` is 0, no compare is made, even if the addresses are equal and the bits differ.
- R3: If a compare is qualified at edge k and the sampled in and out bits differ, `card_err_o` reads 1 after edge k+1.
- R4: In encode mode (`mode_i` = 0), the incoming bit is `code_i[i]` and the outgoing bit is `dout_i[i]`. The index i starts at 0 after reset and advances by one, wrapping from CODE_W-1 to 0, at each edge that samples a qualified compare.
- R5: In recovery mode (`mode_i` = 1), the incoming bit is `rx2_i` and the outgoing bit is `dout_i[0]`, and the index i holds its value.
- R6: Take a qualified compare sampled at edge m. If no further qualified compare is sampled after it, `card_err_o` reads 1 after edge m+1+WD_TIMEOUT and not before.
- R7: The timing watchdog is kicked by `te_strobe_i` in encode mode and by `tr_strobe_i` in recovery mode; the unselected strobe has no effect. Take a kick sampled at edge s. If no other kick is sampled after it, `card_err_o` reads 1 after edge s+WD_TIMEOUT.
- R8: If `rx1_i` differs from `rx2_i` at an edge, `card_err_o` reads 1 after that edge.
- R9: The card error is the OR of the four sticky fault flags. Those flags hold until an edge samples `clr_err_i` = 1, which clears them, and clear takes priority over new faults at that edge.
- R10: While the word index equals DIAG_WORD (24), `stuff_req_no` equals the inverse of `card_err_o`. In every other word, it equals the inverse of `pos_stuff_i`.
- R11: The word index becomes 0 after an edge that samples `frame_start_i` = 1. Otherwise it increments once per edge and wraps from FRAME_WORDS-1 (31) to 0.
- R12: Reset clears the fault flags, the word index and the code bit index, and reloads both watchdogs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_err_i | input | 1 | Synchronous clear of the sticky faults |
| wr_addr_i | input | ADDR_W | Latched buffer write address |
| rd_addr_i | input | ADDR_W | Buffer read counter address |
| gate_i | input | 1 | Gated clock qualifier for compares |
| mode_i | input | 1 | Data source select: 0 encode, 1 recovery |
| code_i | input | CODE_W | Duplicated transition code (buffer input) |
| rx1_i | input | 1 | Conditioned data, receiver 1 |
| rx2_i | input | 1 | Conditioned data, receiver 2 |
| dout_i | input | CODE_W | Buffer output word |
| te_strobe_i | input | 1 | Encode timing strobe |
| tr_strobe_i | input | 1 | Recovery timing strobe |
| frame_start_i | input | 1 | Restarts the word index |
| pos_stuff_i | input | 1 | Positive stuff request from the decoder, active high |
| card_err_o | output | 1 | Card error, OR of the sticky faults |
| stuff_req_no | output | 1 | Shared stuff request/status line, active low |

## Verification
The hardest condition to reach is a data fault on one particular code bit. The compare index advances only on qualified compares, so the stimulus must know which bit is being examined before it can corrupt that bit on the output. The bench tracks the index in its reference model. It produces targeted mismatches in directed runs, and in random runs it corrupts the output word while address equality and the gate are biased high. Watchdog expiry takes a long run of starved cycles without any other fault. Directed windows therefore hold the strobes or the address equality off on purpose while the other inputs stay clean.

// File: rtl/bscm_pkg.sv
package bscm_pkg;
  typedef enum logic {
    MODE_ENC = 1'b0,
    MODE_REC = 1'b1
  } src_mode_e;

  typedef struct packed {
    logic rx_mis;
    logic tm_lost;
    logic en_lost;
    logic data_mis;
  } err_vec_t;

  localparam int unsigned NUM_WD = 2;
  localparam int unsigned WD_EN  = 0;
  localparam int unsigned WD_TM  = 1;
endpackage

// File: rtl/bscm_addr_data_cmp.sv
module bscm_addr_data_cmp
  import bscm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              gate_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rx2_i,
  input  logic [CODE_W-1:0] dout_i,
  output logic              cmp_en_o,
  output logic              mismatch_o
);
  localparam int unsigned IW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(CODE_W - 1);

  logic          addr_eq, en_d;
  logic          en_q, din_q, dout_q;
  logic          din_d, dout_d;
  logic [IW-1:0] idx_q, idx_d;

  assign addr_eq = (wr_addr_i == rd_addr_i);
  assign en_d    = addr_eq & gate_i;

  always_comb begin
    if (src_mode_e'(mode_i) == MODE_REC) begin
      din_d  = rx2_i;
      dout_d = dout_i[0];
    end else begin
      din_d  = code_i[idx_q];
      dout_d = dout_i[idx_q];
    end
  end

  // step through code bits, one per qualified compare
  always_comb begin
    idx_d = idx_q;
    if (src_mode_e'(mode_i) == MODE_ENC && en_d)
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      din_q  <= 1'b0;
      dout_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      en_q   <= en_d;
      din_q  <= din_d;
      dout_q <= dout_d;
      idx_q  <= idx_d;
    end
  end

  assign cmp_en_o   = en_q;
  assign mismatch_o = en_q & (din_q ^ dout_q);

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST); // R4

  AST_MIS_NEEDS_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> $past(wr_addr_i == rd_addr_i)); // R1

  AST_MIS_NEEDS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> $past(gate_i)); // R2
endmodule

// File: rtl/bscm_activity_wd.sv
module bscm_activity_wd #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RELOAD;
    else if (kick_i)           cnt_q <= RELOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_WD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> !$past(kick_i)); // R6

  AST_WD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !kick_i |=> expired_o); // R7
endmodule

// File: rtl/bscm_slot_sel.sv
module bscm_slot_sel #(
  parameter int unsigned FRAME_WORDS = 32,
  parameter int unsigned DIAG_WORD   = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic card_err_i,
  input  logic pos_stuff_i,
  output logic stuff_req_no
);
  localparam int unsigned WW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [WW-1:0] W_LAST = WW'(FRAME_WORDS - 1);
  localparam logic [WW-1:0] W_DIAG = WW'(DIAG_WORD);

  logic [WW-1:0] word_q;
  logic          diag_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                word_q <= '0;
    else if (frame_start_i)     word_q <= '0;
    else if (word_q == W_LAST)  word_q <= '0;
    else                        word_q <= word_q + 1'b1;
  end

  assign diag_slot    = (word_q == W_DIAG);
  assign stuff_req_no = diag_slot ? ~card_err_i : ~pos_stuff_i;

  AST_WORD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i && word_q == W_LAST |=> word_q == '0); // R11

  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !diag_slot || W_DIAG == '0); // R11
endmodule

// File: rtl/buf_selfcheck_mon.sv
module buf_selfcheck_mon
  import bscm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned WD_TIMEOUT  = 64,
  parameter int unsigned FRAME_WORDS = 32,
  parameter int unsigned DIAG_WORD   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_err_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              gate_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rx1_i,
  input  logic              rx2_i,
  input  logic [CODE_W-1:0] dout_i,
  input  logic              te_strobe_i,
  input  logic              tr_strobe_i,
  input  logic              frame_start_i,
  input  logic              pos_stuff_i,
  output logic              card_err_o,
  output logic              stuff_req_no
);
  logic              cmp_en, data_mis;
  logic [NUM_WD-1:0] wd_kick, wd_exp;
  err_vec_t          err_set, err_q;

  bscm_addr_data_cmp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_addr_i  (wr_addr_i),
    .rd_addr_i  (rd_addr_i),
    .gate_i     (gate_i),
    .mode_i     (mode_i),
    .code_i     (code_i),
    .rx2_i      (rx2_i),
    .dout_i     (dout_i),
    .cmp_en_o   (cmp_en),
    .mismatch_o (data_mis)
  );

  assign wd_kick[WD_EN] = cmp_en;
  assign wd_kick[WD_TM] = (src_mode_e'(mode_i) == MODE_REC) ? tr_strobe_i : te_strobe_i;

  for (genvar g = 0; g < NUM_WD; g++) begin : g_wd
    bscm_activity_wd #(.TIMEOUT(WD_TIMEOUT)) u_wd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .kick_i    (wd_kick[g]),
      .expired_o (wd_exp[g])
    );
  end

  always_comb begin
    err_set          = '0;
    err_set.data_mis = data_mis;
    err_set.en_lost  = wd_exp[WD_EN];
    err_set.tm_lost  = wd_exp[WD_TM];
    err_set.rx_mis   = rx1_i ^ rx2_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= '0;
    else if (clr_err_i) err_q <= '0;
    else                err_q <= err_q | err_set;
  end

  assign card_err_o = |err_q;

  bscm_slot_sel #(.FRAME_WORDS(FRAME_WORDS), .DIAG_WORD(DIAG_WORD)) u_slot (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .card_err_i    (card_err_o),
    .pos_stuff_i   (pos_stuff_i),
    .stuff_req_no  (stuff_req_no)
  );

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_err_o && !clr_err_i |=> card_err_o); // R9

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_i |=> !card_err_o); // R9

  AST_RX_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx1_i != rx2_i) && !clr_err_i |=> card_err_o); // R8

  AST_DATA_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_mis && !clr_err_i |=> card_err_o); // R3
endmodule

// File: tb/buf_selfcheck_mon_test.sv
module buf_selfcheck_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, CW = 3, TO = 64, WORDS = 32, DIAG = 24;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, gate = 1'b0, mode = 1'b0;
  logic [AW-1:0] wr = '0, rd = '0;
  logic [CW-1:0] code = '0, dout = '0;
  logic rx1 = 1'b0, rx2 = 1'b0, te = 1'b0, tr = 1'b0, fs = 1'b0, ps = 1'b0;
  logic card_err, stuff_n;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R12";

  bit m_en, m_din, m_dout;
  int m_idx, m_word;
  int m_cnt[2];
  bit [3:0] m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  buf_selfcheck_mon #(.ADDR_W(AW), .CODE_W(CW), .WD_TIMEOUT(TO),
                      .FRAME_WORDS(WORDS), .DIAG_WORD(DIAG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_err_i(clr), .wr_addr_i(wr), .rd_addr_i(rd),
    .gate_i(gate), .mode_i(mode), .code_i(code), .rx1_i(rx1), .rx2_i(rx2),
    .dout_i(dout), .te_strobe_i(te), .tr_strobe_i(tr), .frame_start_i(fs),
    .pos_stuff_i(ps), .card_err_o(card_err), .stuff_req_no(stuff_n));

  function automatic void model_reset();
    m_en = 0; m_din = 0; m_dout = 0; m_idx = 0; m_word = 0; m_err = '0;
    m_cnt[0] = TO - 1; m_cnt[1] = TO - 1;
  endfunction

  function automatic void model_edge();
    bit n_en, n_din, n_dout, k0, k1;
    int n_idx;
    bit [3:0] set;
    n_en   = (wr == rd) && gate;
    n_din  = mode ? rx2 : code[m_idx];
    n_dout = mode ? dout[0] : dout[m_idx];
    n_idx  = m_idx;
    if (!mode && n_en) n_idx = (m_idx == CW - 1) ? 0 : m_idx + 1;
    set[0] = m_en && (m_din != m_dout);
    set[1] = (m_cnt[0] == 0);
    set[2] = (m_cnt[1] == 0);
    set[3] = (rx1 != rx2);
    k0 = m_en;
    k1 = mode ? tr : te;
    m_cnt[0] = k0 ? TO - 1 : (m_cnt[0] > 0 ? m_cnt[0] - 1 : 0);
    m_cnt[1] = k1 ? TO - 1 : (m_cnt[1] > 0 ? m_cnt[1] - 1 : 0);
    m_err  = clr ? 4'b0 : (m_err | set);
    m_word = fs ? 0 : (m_word == WORDS - 1 ? 0 : m_word + 1);
    m_en = n_en; m_din = n_din; m_dout = n_dout; m_idx = n_idx;
  endfunction

  function automatic bit exp_err();
    return |m_err;
  endfunction

  function automatic bit exp_stuff();
    return (m_word == DIAG) ? !exp_err() : !ps;
  endfunction

  task automatic check(input bit act, input bit exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    check(card_err, exp_err(), cur_req, "card_err_o");
    check(stuff_n, exp_stuff(), "R10", "stuff_req_no");
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    #1;
    compare_outputs();
    @(negedge clk);
  endtask

  task automatic good();
    wr = AW'($urandom); rd = wr; gate = 1; clr = 0; fs = 0;
    code = CW'($urandom); dout = code;
    rx2 = 1'($urandom); rx1 = rx2;
    if (mode) dout[0] = rx2;
    te = 1; tr = 1; ps = 1'($urandom);
  endtask

  task automatic clear_now();
    good(); clr = 1; step(); clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    // R12: reset state
    cur_req = "R12";
    good();
    step(); step();
    rst_n = 1;
    check(card_err, 1'b0, "R12", "card_err_o after reset");
    check(stuff_n, !ps, "R12", "stuff_req_no after reset");
    for (int i = 0; i < 8; i++) begin good(); step(); end

    // R1: bits differ with unequal addresses
    cur_req = "R1";
    for (int i = 0; i < 6; i++) begin
      good(); rd = wr + 1'b1; dout = ~code; step();
    end
    good(); step(); good(); step();
    check(card_err, 1'b0, "R1", "no compare when addresses differ");

    // R2: gate low
    cur_req = "R2";
    for (int i = 0; i < 6; i++) begin good(); gate = 0; dout = ~code; step(); end
    good(); step(); good(); step();
    check(card_err, 1'b0, "R2", "no compare when gate low");

    // R3/R4: mismatch on the bit currently indexed, then on other bits
    cur_req = "R4";
    for (int b = 0; b < CW; b++) begin
      int tgt;
      good(); tgt = m_idx; dout[(tgt + 1) % CW] = ~code[(tgt + 1) % CW]; step();
      good(); step(); good(); step();
      check(card_err, (CW == 1), "R4", "unindexed bit ignored");
      clear_now();
      cur_req = "R3";
      good(); tgt = m_idx; dout[tgt] = ~code[tgt]; step();
      good(); step();
      check(card_err, 1'b1, "R3", "indexed bit mismatch flagged");
      clear_now();
      cur_req = "R9";
      good(); step();
      check(card_err, 1'b0, "R9", "cleared and stays clear");
      cur_req = "R4";
    end

    // R5: recovery mode
    cur_req = "R5";
    mode = 1;
    for (int i = 0; i < 5; i++) begin good(); dout[CW-1:1] = ~code[CW-1:1]; step(); end
    check(card_err, 1'b0, "R5", "upper bits ignored in recovery");
    good(); dout[0] = ~rx2; step(); good(); step();
    check(card_err, 1'b1, "R5", "rx2 vs dout[0] mismatch");
    clear_now();
    mode = 0;

    // R6: starve compare enables
    cur_req = "R6";
    for (int i = 0; i < TO - 2; i++) begin good(); rd = wr + 1'b1; step(); end
    check(card_err, 1'b0, "R6", "before enable timeout");
    for (int i = 0; i < 6; i++) begin good(); rd = wr + 1'b1; step(); end
    check(card_err, 1'b1, "R6", "enable timeout");
    for (int i = 0; i < 3; i++) begin good(); step(); end
    clear_now();
    good(); step(); good(); step();

    // R7: only the unselected strobe toggles
    cur_req = "R7";
    for (int i = 0; i < TO + 4; i++) begin good(); te = 0; tr = 1; step(); end
    check(card_err, 1'b1, "R7", "encode mode ignores tr strobe");
    for (int i = 0; i < 3; i++) begin good(); step(); end
    clear_now();
    mode = 1;
    for (int i = 0; i < TO + 4; i++) begin good(); te = 0; tr = (i % 8 == 0); step(); end
    check(card_err, 1'b0, "R7", "recovery mode kicked by tr strobe");
    mode = 0;
    for (int i = 0; i < 3; i++) begin good(); step(); end

    // R8: receiver mismatch
    cur_req = "R8";
    good(); rx1 = ~rx2; step();
    check(card_err, 1'b1, "R8", "receiver mismatch");
    clear_now();

    // R10/R11: slot selection across frames with an error present
    cur_req = "R11";
    good(); fs = 1; step();
    for (int i = 0; i < 2 * WORDS + 5; i++) begin
      good();
      if (i == 30) rx1 = ~rx2;
      step();
    end
    clear_now();

    // random mix
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      good();
      if ($urandom_range(3) == 0) rd = AW'($urandom);
      gate = ($urandom_range(3) != 0);
      if ($urandom_range(15) == 0) dout = CW'($urandom);
      if ($urandom_range(63) == 0) rx1 = ~rx2;
      te = ($urandom_range(1) == 0); tr = ($urandom_range(1) == 0);
      clr = ($urandom_range(7) == 0);
      fs = ($urandom_range(47) == 0);
      if ($urandom_range(255) == 0) mode = ~mode;
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule